// File: doc/BRIEF.md
# Command Mailbox with Chunked Readback

This block is the device-side register set that sits behind a host control window. The host places a command, made of an opcode and a queue index, in a 32-bit register. The device forwards it to a local back end. For a read command, the device streams the payload back through a small data window in chunks. For a bare command, it answers with an acknowledge and an error code only. A legacy mode drops the control register altogether. In that mode the device acknowledges a command by zeroing the opcode register.

The host side is a plain single-cycle register port: a write strobe, a word offset and write data, with read data returned combinationally for the offset presented. The window is laid out as follows. Word 0 is the opcode register: opcode in bits 15:0, queue index in bits 31:16. Word 1 is the control register: size in words in bits 15:0, busy in bit 16, chunk-ready in bit 17, error code in bits 27:18. Word 2 is reserved. The chunk data starts at word 3.

The back-end side uses three valid/ready streams.
- Command stream (out): carries the opcode, the queue index and the buffer size the host asked for. The command is held stable until it is accepted. The one exception is a host abort, which withdraws it.
- Response stream (in): carries a payload length and a 10-bit error code.
- Payload stream (in): on success, the back end must send exactly min(length, requested size) words, and none on error. The device lowers its payload ready whenever its chunk store is full and waiting for the host.

While the mailbox is idle, it accepts and discards any stale response or payload.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, words 0 to 3 of the window read as 0 and no command is offered to the back end.
- R2: While a command runs, word 0 reads back {queue, opcode}. The command stream carries the same opcode and queue, plus the size field from word 1 as the requested word count. Word 2 always reads 0.
- R3: Each chunk presents min(remaining, DEPTH) words starting at data index 0, with the size field set to that count and bit 17 set to 1. Bit 16 stays 1 while words remain after this chunk and is 0 on the final chunk.
- R4: The next chunk is not presented until the host writes word 1 with bit 17 = 0. Until then the control word and the data words stay unchanged.
- R5: The total number of words delivered equals min(back-end length, requested size), in stream order.
- R6: For a read with a requested size above 0, word 0 becomes 0 as soon as the final chunk is presented, with no host acknowledge.
- R7: A command started with size 0 is answered with bit 17 = 1, size 0 and bit 16 = 0. Word 0 keeps the opcode until the host clears bit 17, and then becomes 0.
- R8: A nonzero back-end error code appears in bits 27:18 with bit 16 = 0 and bit 17 = 1. Word 0 becomes 0 at once and no data is delivered. The next command clears the error field.
- R9: In legacy mode (legacy_mode = 1 when the command starts), writes to word 1 have no effect and the requested count sent to the back end is 0. Word 0 becomes 0 once the back-end response is accepted.
- R10: A host write to word 0 with bits 15:0 = 0 makes the mailbox idle on the next edge: word 0 reads 0, and bits 16 and 17 read 0.
- R11: A data word whose index is at or beyond the current chunk length reads 0.
- R12: Host writes to word 1 change only the size field, and only while idle, and can only clear bit 17, never set it. Bit 16 and bits 27:18 are not writable.
- R13: The command stays valid with a stable opcode until it is accepted. No payload word is taken while a chunk awaits the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Selects the opcode-only handshake for the next command |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host word offset into the window |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cmd_valid | output | 1 | Command offered to the back end |
| cmd_ready | input | 1 | Back end accepts the command |
| cmd_opcode | output | 16 | Command opcode |
| cmd_queue | output | 16 | Command queue index |
| cmd_words | output | 16 | Words requested by the host (0 in legacy mode) |
| rsp_valid | input | 1 | Back-end response valid |
| rsp_ready | output | 1 | Device accepts the response |
| rsp_len | input | 16 | Payload length the back end has |
| rsp_err | input | 10 | Error code, 0 for success |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Device accepts a payload word |
| pay_data | input | 32 | Payload word |

## Verification
The hardest situation to reach is a chunk parked in the data window while the back end still holds more payload. The bench asks for 40 words against a 16-word store, then stalls the host for twenty cycles at the first chunk. During the stall it writes a size and a chunk-ready value that must be ignored, and re-reads the window to show nothing moved. An abort in the middle of a command is reached by muting the responder, so that the mailbox sits waiting for a response when the host zeroes the opcode. A follow-on read then proves the mailbox recovered.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RESP,
    ST_FILL,
    ST_ACK
  } mbx_state_e;

  localparam int OP_WORD    = 0;
  localparam int CTL_WORD   = 1;
  localparam int DATA_BASE  = 3;
  localparam int BUSY_BIT   = 16;
  localparam int READY_BIT  = 17;
  localparam int ERR_LSB    = 18;
  localparam int ERR_W      = 10;
endpackage

// File: rtl/mbx_chunk_buf.sv
module mbx_chunk_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [DEPTH-1:0][31:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == AW'(g)) q <= wr_data;
    end
    assign words[g] = q;
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_idx) < DEPTH) rd_data = words[rd_idx];
  end
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             op_wr,
  input  logic             ctl_wr,
  input  logic [31:0]      wdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [15:0]      rsp_len,
  input  logic [ERR_W-1:0] rsp_err,
  input  logic             pay_valid,
  output logic             pay_ready,
  output logic             buf_we,
  output logic [AW-1:0]    buf_widx,
  output logic [15:0]      opcode_q,
  output logic [15:0]      queue_q,
  output logic [15:0]      size_q,
  output logic             inproc_q,
  output logic             crdy_q,
  output logic [ERR_W-1:0] err_q,
  output logic [15:0]      chunk_len_q,
  output logic [15:0]      req_q
);
  localparam logic [15:0] DEPTH16 = 16'(DEPTH);

  mbx_state_e  state_q;
  logic        leg_q;
  logic [15:0] remain_q;
  logic [15:0] fill_cnt_q;
  logic [15:0] target;
  logic        fill_done;
  logic        frc_idle;
  logic        ack_wr;

  assign target    = (remain_q < DEPTH16) ? remain_q : DEPTH16;
  assign fill_done = (fill_cnt_q == target);
  assign frc_idle  = op_wr && (wdata[15:0] == 16'h0);
  assign ack_wr    = ctl_wr && !wdata[READY_BIT];

  assign cmd_valid = (state_q == ST_ISSUE);
  assign rsp_ready = (state_q == ST_RESP) || (state_q == ST_IDLE);
  assign pay_ready = ((state_q == ST_FILL) && !fill_done) || (state_q == ST_IDLE);
  assign buf_we    = (state_q == ST_FILL) && !fill_done && pay_valid;
  assign buf_widx  = fill_cnt_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      leg_q       <= 1'b0;
      opcode_q    <= '0;
      queue_q     <= '0;
      size_q      <= '0;
      inproc_q    <= 1'b0;
      crdy_q      <= 1'b0;
      err_q       <= '0;
      chunk_len_q <= '0;
      req_q       <= '0;
      remain_q    <= '0;
      fill_cnt_q  <= '0;
    end else if (frc_idle) begin
      opcode_q <= '0;
      queue_q  <= '0;
      inproc_q <= 1'b0;
      crdy_q   <= 1'b0;
      state_q  <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (op_wr) begin
            opcode_q <= wdata[15:0];
            queue_q  <= wdata[31:16];
            leg_q    <= legacy_mode;
            req_q    <= legacy_mode ? 16'h0 : size_q;
            state_q  <= ST_ISSUE;
            if (!legacy_mode) begin
              err_q       <= '0;
              crdy_q      <= 1'b0;
              chunk_len_q <= '0;
              inproc_q    <= 1'b1;
            end
          end else if (ctl_wr && !legacy_mode) begin
            size_q <= wdata[15:0];
            if (!wdata[READY_BIT]) crdy_q <= 1'b0;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_valid) begin
            if (leg_q) begin
              opcode_q <= '0;
              queue_q  <= '0;
              state_q  <= ST_IDLE;
            end else if (rsp_err != '0) begin
              err_q       <= rsp_err;
              inproc_q    <= 1'b0;
              crdy_q      <= 1'b1;
              size_q      <= '0;
              chunk_len_q <= '0;
              opcode_q    <= '0;
              queue_q     <= '0;
              state_q     <= ST_IDLE;
            end else begin
              remain_q   <= (rsp_len < req_q) ? rsp_len : req_q;
              fill_cnt_q <= '0;
              state_q    <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (buf_we) fill_cnt_q <= fill_cnt_q + 16'h1;
          if (fill_done) begin
            size_q      <= target;
            chunk_len_q <= target;
            crdy_q      <= 1'b1;
            remain_q    <= remain_q - target;
            inproc_q    <= (remain_q != target);
            if (remain_q != target) begin
              state_q <= ST_ACK;
            end else if (req_q == 16'h0) begin
              state_q <= ST_ACK;
            end else begin
              opcode_q <= '0;
              queue_q  <= '0;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (ack_wr) begin
            crdy_q <= 1'b0;
            if (inproc_q) begin
              fill_cnt_q <= '0;
              state_q    <= ST_FILL;
            end else begin
              opcode_q <= '0;
              queue_q  <= '0;
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_opcode,
  output logic [15:0]       cmd_queue,
  output logic [15:0]       cmd_words,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [15:0]       rsp_len,
  input  logic [9:0]        rsp_err,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [31:0]       pay_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             op_wr, ctl_wr;
  logic             buf_we;
  logic [AW-1:0]    buf_widx;
  logic [15:0]      opcode_q, queue_q, size_q, chunk_len_q, req_q;
  logic             inproc_q, crdy_q;
  logic [ERR_W-1:0] err_q;
  logic [ADDR_W-1:0] didx;
  logic             in_chunk;
  logic [31:0]      buf_rdata;

  assign op_wr  = reg_wr_en && (reg_addr == ADDR_W'(OP_WORD));
  assign ctl_wr = reg_wr_en && (reg_addr == ADDR_W'(CTL_WORD));

  mbx_fsm #(.DEPTH(DEPTH), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .op_wr(op_wr), .ctl_wr(ctl_wr), .wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_len(rsp_len), .rsp_err(rsp_err),
    .pay_valid(pay_valid), .pay_ready(pay_ready),
    .buf_we(buf_we), .buf_widx(buf_widx),
    .opcode_q(opcode_q), .queue_q(queue_q), .size_q(size_q),
    .inproc_q(inproc_q), .crdy_q(crdy_q), .err_q(err_q),
    .chunk_len_q(chunk_len_q), .req_q(req_q)
  );

  assign didx     = reg_addr - ADDR_W'(DATA_BASE);
  assign in_chunk = (reg_addr >= ADDR_W'(DATA_BASE)) && (32'(didx) < 32'(chunk_len_q));

  mbx_chunk_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(pay_data),
    .rd_idx(didx[AW-1:0]), .rd_data(buf_rdata)
  );

  assign cmd_opcode = opcode_q;
  assign cmd_queue  = queue_q;
  assign cmd_words  = req_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OP_WORD))       reg_rdata = {queue_q, opcode_q};
    else if (reg_addr == ADDR_W'(CTL_WORD)) reg_rdata = {4'h0, err_q, crdy_q, inproc_q, size_q};
    else if (in_chunk)                      reg_rdata = buf_rdata;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              legacy_mode,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       wr_low,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [15:0]       cmd_opcode,
  input logic              pay_ready,
  input logic [15:0]       opcode_q,
  input logic [15:0]       size_q,
  input logic              inproc_q,
  input logic              crdy_q,
  input logic [9:0]        err_q,
  input logic [15:0]       chunk_len_q
);
  logic abort_wr;
  assign abort_wr = reg_wr_en && (reg_addr == '0) && (wr_low == 16'h0);

  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !abort_wr |=> cmd_valid && $stable(cmd_opcode));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (opcode_q == 16'h0) && !inproc_q && !crdy_q);

  p_chunk_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crdy_q) |-> (32'(chunk_len_q) <= DEPTH));

  p_no_fill_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crdy_q && inproc_q |-> !pay_ready);

  p_err_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 10'h0) |-> !inproc_q);

  p_legacy_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && (reg_addr == ADDR_W'(1)) && legacy_mode && (opcode_q == 16'h0)
    |=> $stable(size_q) && $stable(crdy_q));
endmodule

bind cmd_mailbox mbx_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .wr_low(reg_wdata[15:0]),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
  .pay_ready(pay_ready), .opcode_q(opcode_q), .size_q(size_q),
  .inproc_q(inproc_q), .crdy_q(crdy_q), .err_q(err_q), .chunk_len_q(chunk_len_q)
);

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 8;

  logic clk, rst_n, legacy_mode;
  logic reg_wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic cmd_valid, cmd_ready;
  logic [15:0] cmd_opcode, cmd_queue, cmd_words;
  logic rsp_valid, rsp_ready;
  logic [15:0] rsp_len;
  logic [9:0] rsp_err;
  logic pay_valid, pay_ready;
  logic [31:0] pay_data;

  cmd_mailbox #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];

  // responder configuration and record
  int          cfg_len = 0;
  logic [9:0]  cfg_err = '0;
  bit          cfg_mute = 0;
  int          cfg_cmd_wait = 0;
  logic [15:0] rec_op, rec_q, rec_words;

  function automatic logic [31:0] pat(input logic [15:0] q, input int i);
    return {q ^ 16'h5A5A, i[15:0]};
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic poll_ctrl(output logic [31:0] v);
    for (int k = 0; k < 500; k++) begin
      reg_read(1, v);
      if (v[17] || v[27:18] != 10'h0) return;
    end
    check_eq("R3 chunk_ready poll timeout", v, 32'h0002_0000);
  endtask

  // responder model: command, response, then payload stream
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_len = '0; rsp_err = '0;
    pay_valid = 1'b0; pay_data = '0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [15:0] op0;
        int n;
        op0 = cmd_opcode;
        repeat (cfg_cmd_wait) @(negedge clk);
        if (cfg_cmd_wait > 0) check_eq("R13 command held while not ready", {16'h0, cmd_opcode}, {16'h0, op0});
        cmd_ready = 1'b1;
        rec_op = cmd_opcode; rec_q = cmd_queue; rec_words = cmd_words;
        @(posedge clk);
        @(negedge clk);
        cmd_ready = 1'b0;
        if (!cfg_mute) begin
          repeat (2) @(negedge clk);
          rsp_valid = 1'b1; rsp_len = 16'(cfg_len); rsp_err = cfg_err;
          forever begin
            #4;
            if (rsp_ready) begin @(posedge clk); break; end
            @(negedge clk);
          end
          @(negedge clk);
          rsp_valid = 1'b0;
          n = (cfg_err != 0) ? 0 : ((cfg_len < int'(rec_words)) ? cfg_len : int'(rec_words));
          for (int i = 0; i < n; i++) begin
            pay_valid = 1'b1; pay_data = pat(rec_q, i);
            forever begin
              #4;
              if (pay_ready) begin @(posedge clk); break; end
              @(negedge clk);
            end
            @(negedge clk);
            pay_valid = 1'b0;
          end
        end
      end
    end
  end

  task automatic host_read(input logic [15:0] op, input logic [15:0] q, input int bufw,
                           input int blen, input logic [9:0] berr, input bit stall);
    logic [31:0] v, d, e, first_word;
    int rem, sz;
    bit first;
    cfg_len = blen; cfg_err = berr;
    rem = (berr != 0) ? 0 : ((blen < bufw) ? blen : bufw);
    for (int i = 0; i < rem; i++) exp_q.push_back(pat(q, i));
    reg_write(1, 32'(bufw));
    reg_write(0, {q, op});
    reg_read(0, v);
    check_eq("R2 opcode word readback while busy", v, {q, op});
    first = 1;
    forever begin
      poll_ctrl(v);
      if (v[27:18] != 10'h0) begin
        check_eq("R8 error field", {22'h0, v[27:18]}, {22'h0, berr});
        check_eq("R8 busy clear and ready set on error", {30'h0, v[17:16]}, 32'h2);
        reg_read(0, d);
        check_eq("R8 opcode cleared on error", d, 32'h0);
        break;
      end
      sz = (rem < DEPTH) ? rem : DEPTH;
      check_eq("R3 chunk size field", {16'h0, v[15:0]}, 32'(sz));
      check_eq("R8 error field clear on success", {22'h0, v[27:18]}, 32'h0);
      for (int i = 0; i < sz; i++) begin
        reg_read(3 + i, d);
        if (exp_q.size() == 0) e = 32'hDEAD_BEEF; else e = exp_q.pop_front();
        if (i == 0) first_word = e;
        check_eq("R5 payload word", d, e);
      end
      rem -= sz;
      check_eq("R3 busy bit vs words remaining", {31'h0, v[16]}, {31'h0, (rem != 0)});
      if (!v[16]) begin
        reg_read(0, d);
        check_eq("R6 opcode cleared after final chunk without ack", d, 32'h0);
        if (sz < DEPTH) begin
          reg_read(3 + sz, d);
          check_eq("R11 word past chunk length", d, 32'h0);
        end
        break;
      end
      if (stall && first) begin
        repeat (20) @(negedge clk);
        reg_read(1, d);
        check_eq("R4 control stable while chunk parked", d, v);
        reg_read(3, d);
        check_eq("R4 R13 data stable while chunk parked", d, first_word);
        reg_write(1, (v & ~32'h0002_FFFF) | 32'h0002_0055);
        reg_read(1, d);
        check_eq("R12 size not writable during command", d, v);
      end
      first = 0;
      reg_write(1, v & ~32'h0002_0000);
    end
    check_eq("R2 command opcode and queue", {rec_q, rec_op}, {q, op});
    check_eq("R2 command requested words", {16'h0, rec_words}, 32'(bufw));
    check_eq("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic host_bare(input logic [15:0] op, input logic [9:0] berr);
    logic [31:0] v, d;
    cfg_len = 0; cfg_err = berr;
    reg_write(1, 32'h0);
    reg_write(0, {16'h0, op});
    poll_ctrl(v);
    check_eq("R7 bare ack size and ready", {14'h0, v[17:16], v[15:0]}, 32'h0002_0000);
    check_eq("R8 bare error code", {22'h0, v[27:18]}, {22'h0, berr});
    reg_read(0, d);
    if (berr == 0) begin
      check_eq("R7 opcode held until host ack", d, {16'h0, op});
      reg_write(1, v & ~32'h0002_0000);
      reg_read(0, d);
      check_eq("R7 opcode cleared after host ack", d, 32'h0);
    end else begin
      check_eq("R8 opcode cleared on bare error", d, 32'h0);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    rst_n = 1'b0; legacy_mode = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      reg_read(a, d);
      check_eq("R1 window reads zero after reset", d, 32'h0);
    end
    check_eq("R1 no command after reset", {31'h0, cmd_valid}, 32'h0);

    host_read(16'd2, 16'd3, 5, 5, 10'h0, 0);           // single chunk
    cfg_cmd_wait = 2;
    host_read(16'd2, 16'd9, 40, 40, 10'h0, 1);         // 16+16+8, parked chunk
    cfg_cmd_wait = 0;
    host_read(16'd2, 16'd1, 6, 20, 10'h0, 0);          // clipped by host size
    host_read(16'd2, 16'd2, 20, 3, 10'h0, 0);          // short back end

    // R12: idle control writes
    reg_write(1, 32'h0);
    reg_write(1, 32'hFFFF_FFFF);
    reg_read(1, d);
    check_eq("R12 idle write changes only size", d, 32'h0000_FFFF);
    reg_write(1, 32'h0);

    host_bare(16'd1, 10'h0);
    host_bare(16'd3, 10'h02A);
    host_read(16'd2, 16'd4, 8, 8, 10'h155, 0);         // read with error
    host_read(16'd4, 16'd8, 2, 2, 10'h0, 0);           // error cleared by next command

    // R9: legacy
    legacy_mode = 1'b1;
    reg_read(1, v);
    reg_write(1, 32'h0002_00AB);
    reg_read(1, d);
    check_eq("R9 legacy control write ignored", d, v);
    cfg_len = 5; cfg_err = 10'h0;
    reg_write(0, {16'd7, 16'd3});
    for (int k = 0; k < 100; k++) begin
      reg_read(0, d);
      if (d == 32'h0) break;
    end
    check_eq("R9 legacy opcode cleared on response", d, 32'h0);
    check_eq("R9 legacy command fields", {rec_q, rec_op}, {16'd7, 16'd3});
    check_eq("R9 legacy requested words zero", {16'h0, rec_words}, 32'h0);
    reg_read(1, d);
    check_eq("R9 legacy control untouched", d, v);
    legacy_mode = 1'b0;

    // R10: abort a command stuck waiting for the back end
    cfg_mute = 1;
    reg_write(1, 32'h4);
    reg_write(0, {16'd5, 16'd2});
    repeat (5) @(negedge clk);
    reg_read(1, d);
    check_eq("R10 busy before abort", {31'h0, d[16]}, 32'h1);
    reg_write(0, 32'h0);
    reg_read(0, d);
    check_eq("R10 opcode zero after abort", d, 32'h0);
    reg_read(1, d);
    check_eq("R10 busy and ready clear after abort", {30'h0, d[17:16]}, 32'h0);
    cfg_mute = 0;
    host_read(16'd2, 16'd6, 3, 3, 10'h0, 0);

    reg_read(2, d);
    check_eq("R2 reserved word reads zero", d, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule